// File: doc/BRIEF.md
# Floating-Point Operand Reader with NaN-Box Validation

This combinational unit sits between a 128-bit floating-point register file and the arithmetic units. It fetches one source operand in the format the instruction asks for: half, bfloat16, single, double or quad. A narrow value kept in a wide register is valid only when every bit above it is one. When that test fails, the reader hands the datapath the canonical quiet NaN of the requested format, and it raises a flag that says a substitution took place. The flag does not set any exception bits.

Half and bfloat16 are both 16 bits wide and share one boxing test. They differ in the NaN that replaces an invalid value: 0x7E00 for half and 0x7FC0 for bfloat16. A second mode takes floating-point operands from the integer register file. In that mode no boxing test is applied. With a 32-bit integer width, a double is assembled from a pair of registers.

Top module: `fpr_operand_reader`

## Requirements
- R1: Format code `fmt_i` is 0 for half, 1 for bfloat16, 2 for single, 3 for double and 4 for quad. Codes 5 to 7 return all zeros with the flag low.
- R2: Double read from the FP register (`int_mode_i`=0): if `fp_reg_i[127:64]` are all ones, the result is `fp_reg_i[63:0]`. Otherwise the result is 0x7FF8000000000000.
- R3: Single read from the FP register: the value is boxed when `fp_reg_i[127:32]` are all ones, and the result is then `fp_reg_i[31:0]`. Otherwise the result is 0x7FC00000.
- R4: Half read from the FP register: the value is boxed when `fp_reg_i[127:16]` are all ones, and the result is then `fp_reg_i[15:0]`. Otherwise the result is 0x7E00.
- R5: A bfloat16 read uses the same test as R4, but an unboxed value yields 0x7FC0. For example, a register whose high 64 bits are ones and whose low 64 bits are 0x0000_0000_0000_7D2D yields 0x7FC0.
- R6: For formats 0 to 3, the result is zero-extended: `operand_o[127:64]` is zero, and so are the bits above the format width.
- R7: A quad read returns `fp_reg_i` unchanged in either mode, with the flag low.
- R8: `nan_sub_o` is high exactly when a canonical NaN replaced an FP-register operand. It is never high in integer-register mode.
- R9: In integer-register mode (`int_mode_i`=1), half, bfloat16 and single take the low 16, 16 or 32 bits of `int_lo_i`, and no boxing check is applied.
- R10: In integer-register mode with `xlen64_i`=1, a double is all 64 bits of `int_lo_i`.
- R11: In integer-register mode with `xlen64_i`=0, a double is {`int_hi_i`, `int_lo_i[31:0]`}, where the even register supplies the low word. When `src_idx_i` is 0, the result is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fp_reg_i | input | 128 | Raw floating-point register contents |
| int_lo_i | input | 64 | Integer source register; the even register of a pair |
| int_hi_i | input | 32 | Low word of the odd register of a pair |
| src_idx_i | input | 5 | Integer source register index |
| fmt_i | input | 3 | Operand format code (R1) |
| xlen64_i | input | 1 | 1 for a 64-bit integer width, 0 for a 32-bit width |
| int_mode_i | input | 1 | 1 to take FP operands from integer registers |
| operand_o | output | 128 | Zero-extended operand |
| nan_sub_o | output | 1 | Canonical NaN was substituted |

## Verification
Two functions can act in the same cycle. The boxing check can reject a value at the moment the integer-register bypass is selected, and the NaN choice for half and bfloat16 depends on the same failed test. The bench provokes the first case by presenting an unboxed FP register together with integer-register mode set. It judges the result by requiring the integer value and a low flag. It provokes the second case by reading one unboxed register as half and as bfloat16 in consecutive vectors, which must return 0x7E00 and 0x7FC0.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  localparam int unsigned QW = 128;
  localparam int unsigned DW = 64;
  localparam int unsigned SW = 32;
  localparam int unsigned HW = 16;

  typedef enum logic [2:0] {
    FMT_HALF = 3'd0,
    FMT_BF16 = 3'd1,
    FMT_SNGL = 3'd2,
    FMT_DBL  = 3'd3,
    FMT_QUAD = 3'd4
  } fmt_e;

  localparam logic [HW-1:0] CNAN_HALF = 16'h7E00;
  localparam logic [HW-1:0] CNAN_BF16 = 16'h7FC0;
  localparam logic [SW-1:0] CNAN_SNGL = 32'h7FC0_0000;
  localparam logic [DW-1:0] CNAN_DBL  = 64'h7FF8_0000_0000_0000;
endpackage

// File: rtl/fpr_box_check.sv
module fpr_box_check
  import fpr_pkg::*;
(
  input  logic [QW-1:0] raw_i,
  output logic          box_d_o,
  output logic          box_s_o,
  output logic          box_h_o
);
  // Each level requires the level above it plus its own band of ones.
  assign box_d_o = &raw_i[QW-1:DW];
  assign box_s_o = box_d_o & (&raw_i[DW-1:SW]);
  assign box_h_o = box_s_o & (&raw_i[SW-1:HW]);
endmodule

// File: rtl/fpr_fp_src.sv
module fpr_fp_src
  import fpr_pkg::*;
(
  input  logic [DW-1:0] low_i,
  input  logic          box_d_i,
  input  logic          box_s_i,
  input  logic          box_h_i,
  input  fmt_e          fmt_i,
  output logic [DW-1:0] val_o,
  output logic          sub_o
);
  always_comb begin
    val_o = '0;
    sub_o = 1'b0;
    unique case (fmt_i)
      FMT_HALF: begin
        val_o[HW-1:0] = box_h_i ? low_i[HW-1:0] : CNAN_HALF;
        sub_o         = ~box_h_i;
      end
      FMT_BF16: begin
        val_o[HW-1:0] = box_h_i ? low_i[HW-1:0] : CNAN_BF16;
        sub_o         = ~box_h_i;
      end
      FMT_SNGL: begin
        val_o[SW-1:0] = box_s_i ? low_i[SW-1:0] : CNAN_SNGL;
        sub_o         = ~box_s_i;
      end
      FMT_DBL: begin
        val_o = box_d_i ? low_i : CNAN_DBL;
        sub_o = ~box_d_i;
      end
      default: begin
        val_o = '0;
        sub_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/fpr_int_src.sv
module fpr_int_src
  import fpr_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic [DW-1:0]    lo_i,
  input  logic [SW-1:0]    hi_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             xlen64_i,
  input  fmt_e             fmt_i,
  output logic [DW-1:0]    val_o
);
  logic pair_zero;
  assign pair_zero = (idx_i == '0);

  always_comb begin
    val_o = '0;
    unique case (fmt_i)
      FMT_HALF, FMT_BF16: val_o[HW-1:0] = lo_i[HW-1:0];
      FMT_SNGL:           val_o[SW-1:0] = lo_i[SW-1:0];
      FMT_DBL: begin
        if (xlen64_i)       val_o = lo_i;
        else if (pair_zero) val_o = '0;
        else                val_o = {hi_i, lo_i[SW-1:0]};
      end
      default:            val_o = '0;
    endcase
  end
endmodule

// File: rtl/fpr_operand_reader.sv
module fpr_operand_reader
  import fpr_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic [127:0]     fp_reg_i,
  input  logic [63:0]      int_lo_i,
  input  logic [31:0]      int_hi_i,
  input  logic [IDX_W-1:0] src_idx_i,
  input  logic [2:0]       fmt_i,
  input  logic             xlen64_i,
  input  logic             int_mode_i,
  output logic [127:0]     operand_o,
  output logic             nan_sub_o
);
  fmt_e          fmt;
  logic          box_d, box_s, box_h;
  logic [DW-1:0] fp_val, int_val;
  logic          fp_sub;

  assign fmt = fmt_e'(fmt_i);

  fpr_box_check u_box (
    .raw_i  (fp_reg_i),
    .box_d_o(box_d),
    .box_s_o(box_s),
    .box_h_o(box_h)
  );

  fpr_fp_src u_fp (
    .low_i  (fp_reg_i[DW-1:0]),
    .box_d_i(box_d),
    .box_s_i(box_s),
    .box_h_i(box_h),
    .fmt_i  (fmt),
    .val_o  (fp_val),
    .sub_o  (fp_sub)
  );

  fpr_int_src #(.IDX_W(IDX_W)) u_int (
    .lo_i    (int_lo_i),
    .hi_i    (int_hi_i),
    .idx_i   (src_idx_i),
    .xlen64_i(xlen64_i),
    .fmt_i   (fmt),
    .val_o   (int_val)
  );

  always_comb begin
    operand_o = '0;
    nan_sub_o = 1'b0;
    unique case (fmt)
      FMT_QUAD: operand_o = fp_reg_i;
      FMT_HALF, FMT_BF16, FMT_SNGL, FMT_DBL: begin
        if (int_mode_i) begin
          operand_o = {{(QW-DW){1'b0}}, int_val};
        end else begin
          operand_o = {{(QW-DW){1'b0}}, fp_val};
          nan_sub_o = fp_sub;
        end
      end
      default: operand_o = '0;
    endcase
  end
endmodule

// File: rtl/fpr_operand_reader_chk.sv
module fpr_operand_reader_chk (
  input logic [127:0] fp_reg_i,
  input logic [2:0]   fmt_i,
  input logic         int_mode_i,
  input logic [127:0] operand_o,
  input logic         nan_sub_o
);
  always_comb begin
    if (fmt_i == 3'd4) begin
      assert_quad_passthru_R7: assert (operand_o == fp_reg_i && !nan_sub_o)
        else $error("quad operand altered");
    end
    if (fmt_i != 3'd4) begin
      assert_upper_zero_R6: assert (operand_o[127:64] == 64'd0)
        else $error("upper half not zero");
    end
    if (int_mode_i) begin
      assert_no_flag_int_R8: assert (!nan_sub_o)
        else $error("flag raised in integer mode");
    end
    if (fmt_i == 3'd1 && nan_sub_o) begin
      assert_bf_canon_R5: assert (operand_o == 128'h7FC0)
        else $error("wrong bfloat16 NaN");
    end
    if (fmt_i == 3'd3 && !int_mode_i && (&fp_reg_i[127:64])) begin
      assert_dbl_boxed_R2: assert (operand_o[63:0] == fp_reg_i[63:0] && !nan_sub_o)
        else $error("boxed double not passed");
    end
    if (fmt_i > 3'd4) begin
      assert_reserved_zero_R1: assert (operand_o == 128'd0 && !nan_sub_o)
        else $error("reserved code not zero");
    end
  end
endmodule

bind fpr_operand_reader fpr_operand_reader_chk u_chk (
  .fp_reg_i  (fp_reg_i),
  .fmt_i     (fmt_i),
  .int_mode_i(int_mode_i),
  .operand_o (operand_o),
  .nan_sub_o (nan_sub_o)
);

// File: tb/sim_fpr_operand_reader.sv
module sim_fpr_operand_reader;
  logic clk;
  logic rst_n;
  logic [127:0] fp_reg;
  logic [63:0]  int_lo;
  logic [31:0]  int_hi;
  logic [4:0]   src_idx;
  logic [2:0]   fmt;
  logic         xlen64;
  logic         int_mode;
  logic [127:0] operand;
  logic         nan_sub;

  int vectors;
  int miscompares;
  bit done;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  fpr_operand_reader u0 (
    .fp_reg_i  (fp_reg),
    .int_lo_i  (int_lo),
    .int_hi_i  (int_hi),
    .src_idx_i (src_idx),
    .fmt_i     (fmt),
    .xlen64_i  (xlen64),
    .int_mode_i(int_mode),
    .operand_o (operand),
    .nan_sub_o (nan_sub)
  );

  localparam logic [63:0] ONES64 = '1;

  // Reference model written from the requirement text.
  function automatic void ref_model(input logic [127:0] f, input logic [63:0] lo,
                                    input logic [31:0] hi, input logic [4:0] idx,
                                    input logic [2:0] fm, input logic x64, input logic im,
                                    output logic [127:0] ev, output logic ef);
    logic bd, bs, bh;
    bd = (f[127:64] == ONES64);
    bs = bd && (f[63:32] == 32'hFFFF_FFFF);
    bh = bs && (f[31:16] == 16'hFFFF);
    ev = '0; ef = 1'b0;
    if (fm == 3'd4) ev = f;
    else if (fm > 3'd4) ev = '0;
    else if (im) begin
      case (fm)
        3'd0, 3'd1: ev = {112'd0, lo[15:0]};
        3'd2: ev = {96'd0, lo[31:0]};
        default: ev = x64 ? {64'd0, lo} : (idx == 0 ? 128'd0 : {64'd0, hi, lo[31:0]});
      endcase
    end else begin
      case (fm)
        3'd0: begin ev = bh ? {112'd0, f[15:0]} : 128'h7E00; ef = !bh; end
        3'd1: begin ev = bh ? {112'd0, f[15:0]} : 128'h7FC0; ef = !bh; end
        3'd2: begin ev = bs ? {96'd0, f[31:0]} : 128'h7FC0_0000; ef = !bs; end
        default: begin ev = bd ? {64'd0, f[63:0]} : 128'h7FF8_0000_0000_0000; ef = !bd; end
      endcase
    end
  endfunction

  task automatic apply(input logic [127:0] f, input logic [63:0] lo, input logic [31:0] hi,
                       input logic [4:0] idx, input logic [2:0] fm, input logic x64,
                       input logic im);
    @(negedge clk);
    fp_reg = f; int_lo = lo; int_hi = hi; src_idx = idx; fmt = fm; xlen64 = x64; int_mode = im;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [127:0] ev, input logic ef);
    vectors++;
    if (operand !== ev || nan_sub !== ef) begin
      miscompares++;
      $display("FAIL %s: actual=%h/%b expected=%h/%b", req, operand, nan_sub, ev, ef);
    end
  endtask

  task automatic run_ref(input string req, input logic [127:0] f, input logic [63:0] lo,
                         input logic [31:0] hi, input logic [4:0] idx, input logic [2:0] fm,
                         input logic x64, input logic im);
    logic [127:0] ev; logic ef;
    apply(f, lo, hi, idx, fm, x64, im);
    ref_model(f, lo, hi, idx, fm, x64, im, ev, ef);
    check(req, ev, ef);
  endtask

  task automatic t_idle();
    apply('0, '0, '0, '0, 3'd0, 1'b0, 1'b0);
    check("R4 idle all-zero half", 128'h7E00, 1'b1);
  endtask

  task automatic t_box_sweep();
    logic [127:0] pats [5];
    pats[0] = {ONES64, 64'h0123_4567_89AB_7D2D};
    pats[1] = {ONES64 & ~(64'd1 << 36), 64'hFFFF_FFFF_FFFF_3C00};
    pats[2] = {ONES64, 64'hFFFF_FEFF_FFFF_4049};
    pats[3] = {ONES64, 64'hFFFF_FFFF_FFF7_1234};
    pats[4] = {64'd0, 64'hFFFF_FFFF_FFFF_3F80};
    for (int p = 0; p < 5; p++)
      for (int fm = 0; fm < 4; fm++)
        run_ref(fm == 3 ? "R2 sweep" : fm == 2 ? "R3 sweep" : fm == 1 ? "R5 sweep" : "R4 sweep",
                pats[p], 64'h1111_2222_3333_4444, 32'h5555_6666, 5'd6, 3'(fm), 1'b1, 1'b0);
    apply({ONES64, 64'hFFFF_FFFF_FFFF_ABCD}, '0, '0, 5'd0, 3'd3, 1'b0, 1'b0);
    check("R2 fully boxed double", {64'd0, 64'hFFFF_FFFF_FFFF_ABCD}, 1'b0);
    apply({ONES64, 64'hFFFF_FFFF_4049_0FDB}, '0, '0, 5'd0, 3'd2, 1'b0, 1'b0);
    check("R3 boxed single / R6 zero-extend", 128'h4049_0FDB, 1'b0);
  endtask

  task automatic t_half_vs_bf();
    logic [127:0] f;
    f = {ONES64, 64'h0000_0000_0000_7D2D};
    apply(f, '0, '0, 5'd0, 3'd0, 1'b0, 1'b0);
    check("R4 unboxed half NaN", 128'h7E00, 1'b1);
    apply(f, '0, '0, 5'd0, 3'd1, 1'b0, 1'b0);
    check("R5 unboxed bf16 NaN", 128'h7FC0, 1'b1);
    apply({ONES64, 64'hFFFF_FFFF_FFFF_7D2D}, '0, '0, 5'd0, 3'd1, 1'b0, 1'b0);
    check("R5 boxed bf16 value", 128'h7D2D, 1'b0);
  endtask

  task automatic t_quad();
    apply(128'hDEAD_BEEF_0000_1111_2222_3333_4444_5555, '1, '1, 5'd3, 3'd4, 1'b0, 1'b0);
    check("R7 quad fp mode", 128'hDEAD_BEEF_0000_1111_2222_3333_4444_5555, 1'b0);
    apply(128'h0, '1, '1, 5'd3, 3'd4, 1'b1, 1'b1);
    check("R7 quad int mode", 128'h0, 1'b0);
  endtask

  task automatic t_int_mode();
    // unboxed FP register together with bypass: integer value, no flag
    apply(128'd0, 64'hAAAA_BBBB_CCCC_DDDD, 32'h1234_5678, 5'd8, 3'd0, 1'b1, 1'b1);
    check("R9/R8 int half, fp unboxed", 128'hDDDD, 1'b0);
    apply(128'd0, 64'hAAAA_BBBB_CCCC_DDDD, 32'h1234_5678, 5'd8, 3'd1, 1'b1, 1'b1);
    check("R9 int bf16", 128'hDDDD, 1'b0);
    apply(128'd0, 64'hAAAA_BBBB_CCCC_DDDD, 32'h1234_5678, 5'd8, 3'd2, 1'b0, 1'b1);
    check("R9 int single", 128'hCCCC_DDDD, 1'b0);
    apply(128'd0, 64'hAAAA_BBBB_CCCC_DDDD, 32'h1234_5678, 5'd8, 3'd3, 1'b1, 1'b1);
    check("R10 int double xlen64", 128'hAAAA_BBBB_CCCC_DDDD, 1'b0);
    for (int fm = 0; fm < 4; fm++)
      run_ref("R8 int sweep", {ONES64 >> 3, 64'h9}, 64'h0F0F_F0F0_1357_9BDF,
              32'h2468_ACE0, 5'd2, 3'(fm), 1'b0, 1'b1);
  endtask

  task automatic t_pair();
    apply('1, 64'hAAAA_BBBB_CCCC_DDDD, 32'h1234_5678, 5'd10, 3'd3, 1'b0, 1'b1);
    check("R11 pair low word from even reg", 128'h1234_5678_CCCC_DDDD, 1'b0);
    apply('1, 64'hAAAA_BBBB_CCCC_DDDD, 32'h1234_5678, 5'd0, 3'd3, 1'b0, 1'b1);
    check("R11 pair at index 0 zero", 128'h0, 1'b0);
  endtask

  task automatic t_reserved();
    for (int fm = 5; fm < 8; fm++) begin
      apply(128'd0, '1, '1, 5'd4, 3'(fm), 1'b0, 1'b0);
      check("R1 reserved code", 128'h0, 1'b0);
    end
  endtask

  initial begin
    vectors = 0; miscompares = 0; done = 1'b0;
    fp_reg = '0; int_lo = '0; int_hi = '0; src_idx = '0; fmt = '0; xlen64 = 1'b0; int_mode = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_idle();
    t_box_sweep();
    t_half_vs_bf();
    t_quad();
    t_int_mode();
    t_pair();
    t_reserved();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule